// File: doc/BRIEF.md
# Sigma-Delta Serial Channel Receiver

This block accepts the one-bit stream coming from an external sigma-delta modulator and delivers it inside the system clock domain as single data bits, each marked by a one-cycle valid strobe. A decimation filter further down the chain consumes these bits. Two line codings are supported. In the clocked serial coding, a bit is captured on one chosen edge of a bit clock. In the Manchester coding, each bit is recovered from the transition in the middle of its bit cell, and the decoded value depends on the selected polarity.

In the clocked serial coding the bit clock can come from several places. It can be an external clock pin. It can be the internally generated clock, used directly. It can also be that internal clock divided by two, with capture on either edge of the halved clock. The serial data can be taken from the channel's own pin or from the neighbouring channel's pin.

Every pin passes through a synchronizer. Every edge is found by comparing synchronized samples, so no flop is clocked by a serial clock. A single configuration write sets all fields. While the channel runs, the coding, clock source and bit-length divider are locked, so a write in that state can only change the enable and the input select.

Top module: `sdrx_chan`

## Requirements
- R1: After reset, `bitValid` and `bitData` are 0 and the channel is disabled.
- R2: With clock source 0 or 1, `cfgType` 0 captures the data on the rising edge of the selected bit clock, and `cfgType` 1 captures it on the falling edge.
- R3: Clock source code 0 selects `extClkIn` and code 1 selects `intClkIn`. Edges on the clock that is not selected produce no output bit.
- R4: Clock source codes 2 and 3 use `intClkIn` divided by two. Code 3 captures on the 1st, 3rd, 5th… rising edge of `intClkIn` after enable, which are the rising edges of the halved clock. Code 2 captures on the 2nd, 4th… rising edge, which are the falling edges of the halved clock. In both cases the value sampled is the one present at that rising edge, whatever the `cfgType` SPI edge.
- R5: With `cfgType` 2, a rising mid-bit transition decodes as 0 and a falling one as 1. With `cfgType` 3 the polarity is opposite: rising decodes as 1 and falling as 0.
- R6: A line transition in a Manchester coding counts as mid-bit in two cases: it is the first transition since enable, or at least `cfgBitDiv - cfgBitDiv/4` system clocks have passed since the last accepted transition. Any other transition, such as a bit-cell boundary, produces no output.
- R7: No bit is produced while the enable is 0. Clearing the enable stops output.
- R8: With `cfgAltIn` set to 1, data is taken from `nbrDataIn` instead of `ownDataIn`.
- R9: A configuration write while the channel is enabled leaves the coding, clock source and divider unchanged. The enable and input select of that write are taken.
- R10: Each received bit produces exactly one `bitValid` pulse lasting one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWr | input | 1 | Configuration write strobe |
| cfgEnable | input | 1 | Channel enable |
| cfgAltIn | input | 1 | 1: take data from the neighbour's pin |
| cfgType | input | 2 | Line coding: 0 SPI rising, 1 SPI falling, 2 Manchester, 3 Manchester inverted |
| cfgClkSrc | input | 2 | 0 external, 1 internal, 2 internal/2 falling, 3 internal/2 rising |
| cfgBitDiv | input | DIV_W | System clocks per Manchester bit |
| extClkIn | input | 1 | External bit clock |
| intClkIn | input | 1 | Internally generated bit clock |
| ownDataIn | input | 1 | Channel's own serial data pin |
| nbrDataIn | input | 1 | Neighbouring channel's serial data pin |
| bitData | output | 1 | Received bit |
| bitValid | output | 1 | One-cycle strobe for `bitData` |

## Verification
The clocked codings are driven with data that flips between the rising and the falling clock edge. A rising-edge capture and a falling-edge capture therefore yield complementary streams, which tells the two SPI types apart and also exposes a half-rate source that takes the wrong edge or the wrong parity of the internal clock. The unselected clock is toggled while the selected one is quiet, and the other data pin always carries the inverse stream, so a wrong source or input select shows up as an extra or inverted bit. The Manchester patterns contain runs of equal bits, which place boundary transitions between mid-bit ones; both polarities are sent, so mis-timed acceptance and inverted decoding are separated.

// File: rtl/sdrx_pkg.sv
package sdrx_pkg;
  typedef enum logic [1:0] {
    LINE_SPI_RISE = 2'd0,
    LINE_SPI_FALL = 2'd1,
    LINE_MAN_A    = 2'd2,
    LINE_MAN_B    = 2'd3
  } line_e;

  typedef enum logic [1:0] {
    SRC_EXT       = 2'd0,
    SRC_INT       = 2'd1,
    SRC_HALF_FALL = 2'd2,
    SRC_HALF_RISE = 2'd3
  } src_e;

  typedef struct packed {
    logic run;
    logic spiTake;
    logic manEdge;
    logic manRise;
    logic dataBit;
  } strb_t;
endpackage

// File: rtl/sdrx_sync.sv
module sdrx_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stg[i] <= '0;
        else       stg[i] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stg[i] <= '0;
        else       stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/sdrx_ctrl.sv
module sdrx_ctrl
  import sdrx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic             cfgEnable,
  input  logic             cfgAltIn,
  input  logic [1:0]       cfgType,
  input  logic [1:0]       cfgClkSrc,
  input  logic [DIV_W-1:0] cfgBitDiv,
  input  logic [3:0]       syncIn,
  output strb_t            strb,
  output line_e            lineType,
  output logic [DIV_W-1:0] bitDiv
);
  localparam int EXT_IDX = 0;
  localparam int INT_IDX = 1;
  localparam int OWN_IDX = 2;
  localparam int NBR_IDX = 3;

  logic enReg, altReg, halfClk;
  line_e typeReg;
  src_e srcReg;
  logic [DIV_W-1:0] divReg;
  logic [3:0] prevS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      altReg  <= 1'b0;
      typeReg <= LINE_SPI_RISE;
      srcReg  <= SRC_EXT;
      divReg  <= '0;
    end else if (cfgWr) begin
      enReg  <= cfgEnable;
      altReg <= cfgAltIn;
      if (!enReg) begin
        typeReg <= line_e'(cfgType);
        srcReg  <= src_e'(cfgClkSrc);
        divReg  <= cfgBitDiv;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevS <= '0;
    else       prevS <= syncIn;

  logic extRise, extFall, intRise, intFall;
  assign extRise = syncIn[EXT_IDX] & ~prevS[EXT_IDX];
  assign extFall = ~syncIn[EXT_IDX] & prevS[EXT_IDX];
  assign intRise = syncIn[INT_IDX] & ~prevS[INT_IDX];
  assign intFall = ~syncIn[INT_IDX] & prevS[INT_IDX];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)        halfClk <= 1'b0;
    else if (!enReg)  halfClk <= 1'b0;
    else if (intRise) halfClk <= ~halfClk;

  logic selData, prevData, isMan, take;
  assign selData  = altReg ? syncIn[NBR_IDX] : syncIn[OWN_IDX];
  assign prevData = altReg ? prevS[NBR_IDX]  : prevS[OWN_IDX];
  assign isMan    = typeReg[1];

  always_comb begin
    unique case (srcReg)
      SRC_EXT:       take = (typeReg == LINE_SPI_FALL) ? extFall : extRise;
      SRC_INT:       take = (typeReg == LINE_SPI_FALL) ? intFall : intRise;
      SRC_HALF_FALL: take = intRise & halfClk;
      default:       take = intRise & ~halfClk;
    endcase
  end

  always_comb begin
    strb.run     = enReg;
    strb.spiTake = enReg & ~isMan & take;
    strb.manEdge = enReg & isMan & (selData ^ prevData);
    strb.manRise = selData & ~prevData;
    strb.dataBit = selData;
  end

  assign lineType = typeReg;
  assign bitDiv   = divReg;

  // R9: a write landing while running keeps the locked fields
  a_r9_cfg_locked: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && enReg) |=> ($stable(typeReg) && $stable(srcReg) && $stable(divReg)));
endmodule

// File: rtl/sdrx_dpath.sv
module sdrx_dpath
  import sdrx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strb_t            strb,
  input  line_e            lineType,
  input  logic [DIV_W-1:0] bitDiv,
  output logic             bitData,
  output logic             bitValid
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt, thr;
  logic locked, accept, manBit;

  assign thr    = {1'b0, bitDiv} - {3'b000, bitDiv[DIV_W-1:2]};
  assign accept = strb.manEdge & (~locked | (cnt >= thr));
  assign manBit = (lineType == LINE_MAN_B) ? strb.manRise : ~strb.manRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (!strb.run) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (accept) begin
      cnt    <= '0;
      locked <= 1'b1;
    end else if (cnt != {CNT_W{1'b1}}) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitValid <= 1'b0;
      bitData  <= 1'b0;
    end else begin
      bitValid <= strb.spiTake | accept;
      if (strb.spiTake)   bitData <= strb.dataBit;
      else if (accept)    bitData <= manBit;
    end
  end

  // R7: output only follows a running channel
  a_r7_valid_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> $past(strb.run));
  // R10: strobe lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> !bitValid);
  // R2: the control never asks for both decoders at once
  a_r2_take_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.spiTake, strb.manEdge}));
  // R6: an early transition after lock gives no bit
  a_r6_early_edge_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (strb.manEdge && locked && (cnt < thr) && !strb.spiTake) |=> !bitValid);
endmodule

// File: rtl/sdrx_chan.sv
module sdrx_chan
  import sdrx_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic             cfgEnable,
  input  logic             cfgAltIn,
  input  logic [1:0]       cfgType,
  input  logic [1:0]       cfgClkSrc,
  input  logic [DIV_W-1:0] cfgBitDiv,
  input  logic             extClkIn,
  input  logic             intClkIn,
  input  logic             ownDataIn,
  input  logic             nbrDataIn,
  output logic             bitData,
  output logic             bitValid
);
  logic [3:0] syncIn;
  strb_t strb;
  line_e lineType;
  logic [DIV_W-1:0] bitDiv;

  sdrx_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN),
    .din({nbrDataIn, ownDataIn, intClkIn, extClkIn}),
    .dout(syncIn)
  );

  sdrx_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgEnable(cfgEnable),
    .cfgAltIn(cfgAltIn), .cfgType(cfgType), .cfgClkSrc(cfgClkSrc),
    .cfgBitDiv(cfgBitDiv), .syncIn(syncIn), .strb(strb),
    .lineType(lineType), .bitDiv(bitDiv)
  );

  sdrx_dpath #(.DIV_W(DIV_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .lineType(lineType),
    .bitDiv(bitDiv), .bitData(bitData), .bitValid(bitValid)
  );
endmodule

// File: tb/sdrx_chan_tb.sv
module sdrx_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWr = 0, cfgEnable = 0, cfgAltIn = 0;
  logic [1:0] cfgType = 0, cfgClkSrc = 0;
  logic [DIV_W-1:0] cfgBitDiv = 0;
  logic extClkIn = 0, intClkIn = 0, ownDataIn = 0, nbrDataIn = 1;
  logic bitData, bitValid;

  int nChecks = 0, nFails = 0;
  bit expBits[$];
  string expTags[$];
  string curTag = "R1";
  bit benchAlt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdrx_chan #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgEnable(cfgEnable),
    .cfgAltIn(cfgAltIn), .cfgType(cfgType), .cfgClkSrc(cfgClkSrc),
    .cfgBitDiv(cfgBitDiv), .extClkIn(extClkIn), .intClkIn(intClkIn),
    .ownDataIn(ownDataIn), .nbrDataIn(nbrDataIn),
    .bitData(bitData), .bitValid(bitValid)
  );

  // monitor / scoreboard
  bit prevValid = 0;
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (bitValid && prevValid) begin
        nChecks++; nFails++;
        $display("FAIL R10: valid high %0d cycles in a row, expected 1", 2);
      end
      if (bitValid) begin
        nChecks++;
        if (expBits.size() == 0) begin
          nFails++;
          $display("FAIL %s: unexpected bit %0b, expected no output", curTag, bitData);
        end else begin
          bit e;
          string t;
          e = expBits.pop_front();
          t = expTags.pop_front();
          if (bitData !== e) begin
            nFails++;
            $display("FAIL %s: bitData=%0b expected %0b", t, bitData, e);
          end
        end
      end
      prevValid = bitValid;
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectBit(input bit v, input string t);
    expBits.push_back(v);
    expTags.push_back(t);
  endtask

  task automatic setData(input bit v);
    if (benchAlt) begin nbrDataIn = v; ownDataIn = ~v; end
    else          begin ownDataIn = v; nbrDataIn = ~v; end
  endtask

  task automatic cfg(input bit en, input bit alt, input logic [1:0] typ,
                     input logic [1:0] src, input logic [DIV_W-1:0] dv);
    @(negedge clk);
    cfgWr = 1; cfgEnable = en; cfgAltIn = alt; cfgType = typ;
    cfgClkSrc = src; cfgBitDiv = dv;
    @(negedge clk);
    cfgWr = 0;
    benchAlt = alt;
    waitN(4);
  endtask

  task automatic setClk(input bit useInt, input bit v);
    if (useInt) intClkIn = v; else extClkIn = v;
  endtask

  // v0 held around rising edge, v1 around falling edge
  task automatic spiBit(input bit useInt, input bit v0, input bit v1);
    setData(v0); waitN(4);
    setClk(useInt, 1); waitN(4);
    setData(v1); waitN(4);
    setClk(useInt, 0); waitN(4);
  endtask

  task automatic spiByte(input bit useInt, input logic [7:0] pat,
                         input bit capFall, input bit expOn, input string t);
    for (int i = 7; i >= 0; i--) begin
      if (expOn) expectBit(capFall ? ~pat[i] : pat[i], t);
      spiBit(useInt, pat[i], ~pat[i]);
    end
    waitN(4);
  endtask

  task automatic manByte(input logic [7:0] pat, input bit inv, input string t);
    for (int i = 7; i >= 0; i--) begin
      bit first;
      first = pat[i] ^ inv;  // rising mid-bit means 0 (normal), 1 (inverted)
      expectBit(pat[i], t);
      setData(first); waitN(8);
      setData(~first); waitN(8);
    end
    waitN(6);
  endtask

  task automatic checkDrained(input string t);
    nChecks++;
    if (expBits.size() != 0) begin
      nFails++;
      $display("FAIL %s: %0d bits missing, expected 0", t, expBits.size());
      expBits.delete(); expTags.delete();
    end
  endtask

  initial begin
    waitN(5);
    nChecks++;
    if (bitValid !== 1'b0 || bitData !== 1'b0) begin
      nFails++;
      $display("FAIL R1: valid=%0b data=%0b expected 0 0", bitValid, bitData);
    end
    rstN = 1;
    waitN(4);

    // R7: disabled channel ignores clocks
    curTag = "R7";
    spiByte(0, 8'h5A, 0, 0, "R7");
    checkDrained("R7");

    // R2: rising capture on external clock
    curTag = "R2";
    cfg(1, 0, 2'd0, 2'd0, 8'd16);
    spiByte(0, 8'hA5, 0, 1, "R2");
    checkDrained("R2");
    // R2: falling capture
    cfg(0, 0, 2'd0, 2'd0, 8'd16);
    cfg(1, 0, 2'd1, 2'd0, 8'd16);
    spiByte(0, 8'h3C, 1, 1, "R2");
    checkDrained("R2");

    // R3: internal clock ignored on source 0
    curTag = "R3";
    spiByte(1, 8'hFF, 0, 0, "R3");
    checkDrained("R3");
    // R3: source 1 uses internal clock, external ignored
    cfg(0, 0, 2'd0, 2'd0, 8'd16);
    cfg(1, 0, 2'd0, 2'd1, 8'd16);
    spiByte(1, 8'h96, 0, 1, "R3");
    spiByte(0, 8'h0F, 0, 0, "R3");
    checkDrained("R3");

    // R9: write while enabled keeps type and source
    curTag = "R9";
    cfg(1, 0, 2'd1, 2'd0, 8'd16);
    spiByte(1, 8'hC3, 0, 1, "R9");
    checkDrained("R9");

    // R7: clearing enable stops output
    curTag = "R7";
    cfg(0, 0, 2'd0, 2'd1, 8'd16);
    spiByte(1, 8'h77, 0, 0, "R7");
    checkDrained("R7");

    // R4: half-rate, code 3 takes odd rising edges
    curTag = "R4";
    cfg(1, 0, 2'd1, 2'd3, 8'd16);
    for (int k = 1; k <= 8; k++) begin
      bit v;
      v = k[0] ^ k[1];
      if (k % 2 == 1) expectBit(v, "R4");
      spiBit(1, v, ~v);
    end
    waitN(4);
    checkDrained("R4");
    // R4: code 2 takes even rising edges
    cfg(0, 0, 2'd0, 2'd0, 8'd16);
    cfg(1, 0, 2'd1, 2'd2, 8'd16);
    for (int k = 1; k <= 8; k++) begin
      bit v;
      v = k[1] ^ k[2];
      if (k % 2 == 0) expectBit(v, "R4");
      spiBit(1, v, ~v);
    end
    waitN(4);
    checkDrained("R4");

    // R8: neighbour pin
    curTag = "R8";
    cfg(0, 1, 2'd0, 2'd0, 8'd16);
    cfg(1, 1, 2'd0, 2'd0, 8'd16);
    spiByte(0, 8'h69, 0, 1, "R8");
    checkDrained("R8");

    // R5: Manchester normal polarity
    curTag = "R5";
    cfg(0, 0, 2'd0, 2'd0, 8'd16);
    setData(1'b1); waitN(6);        // first half of bit 1 in normal coding
    cfg(1, 0, 2'd2, 2'd0, 8'd16);
    manByte(8'hC6, 0, "R5");
    checkDrained("R5");

    // R6: inverted polarity, runs of equal bits put boundary edges in between
    curTag = "R6";
    cfg(0, 0, 2'd0, 2'd0, 8'd16);
    setData(1'b1); waitN(6);        // first half of bit 0 in inverted coding
    cfg(1, 0, 2'd3, 2'd0, 8'd16);
    manByte(8'h1E, 1, "R6");
    checkDrained("R6");

    cfg(0, 0, 2'd0, 2'd0, 8'd16);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule